// File: doc/BRIEF.md
# FDDI Symbol-Pair Transmit Encoder

This block sits on the transmit side of an FDDI physical layer. Once every byte period it takes one symbol-pair byte from the MAC-side request port. The byte holds a control flag, two 4-bit symbols and an odd-parity bit. The block turns each symbol into its 5-bit line code and shifts the resulting 10 code bits out serially, most significant bit first. A single clock runs at the bit rate, so ten clocks make one byte period, as at 125 Mbit/s with a 12.5 MHz byte rate. The block pulses `byte_take` in the cycle at whose closing edge it captures the request inputs.

A byte with a parity error, or a control byte that names no legal control symbol, never reaches the line: it is replaced by a Halt pair. A line-state request on `ls_mode` overrides the data with one of these fixed streams:

- continuous Idle
- Master (Halt then Quiet)
- continuous Halt
- continuous Quiet
- a software-chosen 10-bit code pair

The serial output can also be NRZI-coded.

Top module: `sympair_tx_enc`

## Requirements
- R1: While `rst` is high, and for the first ten clock edges after it falls, `line_out` is 0. While `rst` is high, `byte_take` is 0.
- R2: `byte_take` is high for exactly one cycle in every ten, first in the 9th cycle after reset. The request inputs are captured at the clock edge that ends that cycle. The captured pair starts on `line_out` one edge later, at one bit per clock and with no gap.
- R3: With `ls_mode`=0, `rq_ctl`=0 and odd parity over {`rq_par`,`rq_ctl`,`rq_hi`,`rq_lo`}, each nibble 0..F is sent as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. The `rq_hi` code is sent first, and each code is sent MSB first.
- R4: With `ls_mode`=0, `rq_ctl`=1 and good parity, nibble values 0..7 select the control codes Q=00000, I=11111, H=00100, J=11000, K=10001, T=01101, R=00111 and S=11001, in that order.
- R5: With `ls_mode`=0, a byte whose parity is even is sent as the Halt pair 00100 00100.
- R6: With `ls_mode`=0, a control byte (`rq_ctl`=1) with either nibble in 8..F is sent as the Halt pair.
- R7: `ls_mode`=1 (Idle) sends 11111 11111, whatever the data and parity inputs hold.
- R8: `ls_mode`=2 (Master) sends the pair H then Q (00100 00000) in every byte period.
- R9: `ls_mode`=3 (Halt) sends H H. `ls_mode`=4 (Quiet), and the unused values 6 and 7, send all zeros.
- R10: `ls_mode`=5 sends `usr_code` unchanged, from bit 9 down to bit 0.
- R11: With `nrzi_en`=0, `line_out` equals the code bit. With `nrzi_en`=1, `line_out` toggles for a code bit of 1 and holds for a code bit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_par | input | 1 | Odd-parity bit of the request byte |
| rq_ctl | input | 1 | Control flag: the nibbles name control symbols |
| rq_hi | input | 4 | First symbol of the pair |
| rq_lo | input | 4 | Second symbol of the pair |
| ls_mode | input | 3 | Line-state request: 0 data, 1 Idle, 2 Master, 3 Halt, 4 Quiet, 5 user pair |
| usr_code | input | 10 | Code pair sent when `ls_mode`=5 |
| nrzi_en | input | 1 | Enable NRZI coding of the serial output |
| byte_take | output | 1 | High in the cycle whose closing edge captures the request inputs |
| line_out | output | 1 | Serial line output |

## Verification
A wrong symbol-map or pair-select result shows within ten to twenty clocks: every bit of the loaded pair reaches `line_out` in order during the ten edges that follow the load. A bit-counter fault shifts the `byte_take` spacing and misaligns the serial stream at once, so the next pair comes out truncated or stretched. A wrong NRZI state makes every later line bit disagree with the running expectation, so one fault keeps failing until the mode is cleared.

// File: rtl/sympair_pkg.sv
package sympair_pkg;
  localparam logic [2:0] LS_DATA   = 3'd0;
  localparam logic [2:0] LS_IDLE   = 3'd1;
  localparam logic [2:0] LS_MASTER = 3'd2;
  localparam logic [2:0] LS_HALT   = 3'd3;
  localparam logic [2:0] LS_QUIET  = 3'd4;
  localparam logic [2:0] LS_USER   = 3'd5;

  localparam logic [4:0] CODE_Q = 5'b00000;
  localparam logic [4:0] CODE_I = 5'b11111;
  localparam logic [4:0] CODE_H = 5'b00100;
  localparam logic [4:0] CODE_J = 5'b11000;
  localparam logic [4:0] CODE_K = 5'b10001;
  localparam logic [4:0] CODE_T = 5'b01101;
  localparam logic [4:0] CODE_R = 5'b00111;
  localparam logic [4:0] CODE_S = 5'b11001;
endpackage

// File: rtl/sympair_sym_map.sv
module sympair_sym_map
  import sympair_pkg::*;
#(
  parameter int SYM_W  = 4,
  parameter int CODE_W = 5
) (
  input  logic              is_ctl,
  input  logic [SYM_W-1:0]  nib,
  output logic [CODE_W-1:0] code,
  output logic              legal
);
  always_comb begin
    legal = 1'b1;
    code  = CODE_H;
    if (!is_ctl) begin
      case (nib)
        4'h0: code = 5'b11110;
        4'h1: code = 5'b01001;
        4'h2: code = 5'b10100;
        4'h3: code = 5'b10101;
        4'h4: code = 5'b01010;
        4'h5: code = 5'b01011;
        4'h6: code = 5'b01110;
        4'h7: code = 5'b01111;
        4'h8: code = 5'b10010;
        4'h9: code = 5'b10011;
        4'hA: code = 5'b10110;
        4'hB: code = 5'b10111;
        4'hC: code = 5'b11010;
        4'hD: code = 5'b11011;
        4'hE: code = 5'b11100;
        default: code = 5'b11101;
      endcase
    end else begin
      case (nib)
        4'h0: code = CODE_Q;
        4'h1: code = CODE_I;
        4'h2: code = CODE_H;
        4'h3: code = CODE_J;
        4'h4: code = CODE_K;
        4'h5: code = CODE_T;
        4'h6: code = CODE_R;
        4'h7: code = CODE_S;
        default: begin
          code  = CODE_H;
          legal = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sympair_pair_sel.sv
module sympair_pair_sel
  import sympair_pkg::*;
#(
  parameter int CODE_W = 5,
  localparam int PAIR_W = 2 * CODE_W
) (
  input  logic [2:0]        mode,
  input  logic              par_ok,
  input  logic              legal_hi,
  input  logic              legal_lo,
  input  logic [CODE_W-1:0] code_hi,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [PAIR_W-1:0] usr_code,
  output logic [PAIR_W-1:0] word
);
  logic bad_byte;

  always_comb begin
    bad_byte = !par_ok || !legal_hi || !legal_lo;
    case (mode)
      LS_DATA:   word = bad_byte ? {CODE_H, CODE_H} : {code_hi, code_lo};
      LS_IDLE:   word = {CODE_I, CODE_I};
      LS_MASTER: word = {CODE_H, CODE_Q};
      LS_HALT:   word = {CODE_H, CODE_H};
      LS_USER:   word = usr_code;
      default:   word = {CODE_Q, CODE_Q};
    endcase
  end
endmodule

// File: rtl/sympair_serializer.sv
module sympair_serializer #(
  parameter int PAIR_W = 10,
  localparam int CNT_W = $clog2(PAIR_W),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAIR_W - 1),
  localparam logic [CNT_W-1:0] PRE  = CNT_W'(PAIR_W - 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PAIR_W-1:0] word,
  input  logic              nrzi_en,
  output logic              take,
  output logic              line
);
  logic [CNT_W-1:0]  cnt;
  logic [PAIR_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sh   <= '0;
      line <= 1'b0;
      take <= 1'b0;
    end else begin
      line <= nrzi_en ? (line ^ sh[PAIR_W-1]) : sh[PAIR_W-1];
      take <= (cnt == PRE);
      if (cnt == LAST) begin
        cnt <= '0;
        sh  <= word;
      end else begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[PAIR_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/sympair_tx_enc.sv
module sympair_tx_enc #(
  parameter int SYM_W  = 4,
  parameter int CODE_W = 5,
  localparam int PAIR_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rq_par,
  input  logic              rq_ctl,
  input  logic [SYM_W-1:0]  rq_hi,
  input  logic [SYM_W-1:0]  rq_lo,
  input  logic [2:0]        ls_mode,
  input  logic [PAIR_W-1:0] usr_code,
  input  logic              nrzi_en,
  output logic              byte_take,
  output logic              line_out
);
  logic [SYM_W-1:0]  nibs  [2];
  logic [CODE_W-1:0] codes [2];
  logic [1:0]        legal;
  logic [PAIR_W-1:0] enc_word;
  logic              par_ok;

  assign nibs[0] = rq_hi;
  assign nibs[1] = rq_lo;
  assign par_ok  = ^{rq_par, rq_ctl, rq_hi, rq_lo};

  for (genvar g = 0; g < 2; g++) begin : g_sym
    sympair_sym_map #(.SYM_W(SYM_W), .CODE_W(CODE_W)) u_map (
      .is_ctl(rq_ctl),
      .nib   (nibs[g]),
      .code  (codes[g]),
      .legal (legal[g])
    );
  end

  sympair_pair_sel #(.CODE_W(CODE_W)) u_sel (
    .mode    (ls_mode),
    .par_ok  (par_ok),
    .legal_hi(legal[0]),
    .legal_lo(legal[1]),
    .code_hi (codes[0]),
    .code_lo (codes[1]),
    .usr_code(usr_code),
    .word    (enc_word)
  );

  sympair_serializer #(.PAIR_W(PAIR_W)) u_ser (
    .clk    (clk),
    .rst    (rst),
    .word   (enc_word),
    .nrzi_en(nrzi_en),
    .take   (byte_take),
    .line   (line_out)
  );
endmodule

// File: rtl/sympair_tx_chk.sv
module sympair_tx_chk #(
  parameter int SYM_W  = 4,
  parameter int PAIR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              take,
  input logic [2:0]        mode,
  input logic              par,
  input logic              ctl,
  input logic [SYM_W-1:0]  hi,
  input logic [SYM_W-1:0]  lo,
  input logic [PAIR_W-1:0] usr,
  input logic [PAIR_W-1:0] word
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (take) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1'b1;
    end
  end

  p_take_single_r2: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);

  p_take_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (take && seen) |-> (gap == 8'(PAIR_W - 1)));

  p_parity_halt_r5: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 3'd0 && (^{par, ctl, hi, lo}) == 1'b0) |-> (word == 10'b00100_00100));

  p_idle_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 3'd1) |-> (word == 10'b11111_11111));

  p_user_pair_r10: assert property (@(posedge clk) disable iff (rst)
    (take && mode == 3'd5) |-> (word == usr));
endmodule

bind sympair_tx_enc sympair_tx_chk #(.SYM_W(SYM_W), .PAIR_W(PAIR_W)) u_chk (
  .clk (clk),
  .rst (rst),
  .take(byte_take),
  .mode(ls_mode),
  .par (rq_par),
  .ctl (rq_ctl),
  .hi  (rq_hi),
  .lo  (rq_lo),
  .usr (usr_code),
  .word(enc_word)
);

// File: tb/sim_sympair_tx_enc.sv
`timescale 1ns/1ps
module sim_sympair_tx_enc;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rq_par = 1'b0, rq_ctl = 1'b0;
  logic [3:0] rq_hi = '0, rq_lo = '0;
  logic [2:0] ls_mode = '0;
  logic [9:0] usr_code = '0;
  logic       nrzi_en = 1'b0;
  logic       byte_take, line_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit    q_bit[$];
  string q_tag[$];

  always #2 clk = ~clk;

  sympair_tx_enc u0 (
    .clk(clk), .rst(rst), .rq_par(rq_par), .rq_ctl(rq_ctl), .rq_hi(rq_hi),
    .rq_lo(rq_lo), .ls_mode(ls_mode), .usr_code(usr_code), .nrzi_en(nrzi_en),
    .byte_take(byte_take), .line_out(line_out)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] dcode(logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
                           5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [4:0] ccode(logic [3:0] n);
    logic [4:0] t [8] = '{5'b00000, 5'b11111, 5'b00100, 5'b11000, 5'b10001,
                          5'b01101, 5'b00111, 5'b11001};
    return t[n[2:0]];
  endfunction

  function automatic logic [9:0] exp_word(output string tag);
    logic [4:0] h = 5'b00100;
    case (ls_mode)
      3'd1: begin tag = "R7 idle";   return 10'h3FF; end
      3'd2: begin tag = "R8 master"; return {h, 5'b00000}; end
      3'd3: begin tag = "R9 halt";   return {h, h}; end
      3'd5: begin tag = "R10 user";  return usr_code; end
      3'd0: begin
        if ((^{rq_par, rq_ctl, rq_hi, rq_lo}) == 1'b0) begin tag = "R5 parity"; return {h, h}; end
        if (rq_ctl) begin
          if (rq_hi > 4'd7 || rq_lo > 4'd7) begin tag = "R6 bad ctl"; return {h, h}; end
          tag = "R4 ctl"; return {ccode(rq_hi), ccode(rq_lo)};
        end
        tag = "R3 data"; return {dcode(rq_hi), dcode(rq_lo)};
      end
      default: begin tag = "R9 quiet"; return 10'h000; end
    endcase
  endfunction

  task automatic pick(int k);
    int j = k % 10;
    logic bad = 1'b0;
    if (k < 20) begin
      nrzi_en = (k >= 10);
      ls_mode = 3'd0; rq_ctl = 1'b0; rq_hi = 4'h0; rq_lo = 4'hF;
      case (j)
        1: begin rq_ctl = 1'b1; rq_hi = 4'h3; rq_lo = 4'h4; end
        2: begin rq_hi = 4'h5; rq_lo = 4'hA; bad = 1'b1; end
        3: begin rq_ctl = 1'b1; rq_hi = 4'h2; rq_lo = 4'h9; end
        4: begin ls_mode = 3'd1; bad = 1'b1; end
        5: ls_mode = 3'd2;
        6: ls_mode = 3'd3;
        7: ls_mode = 3'd4;
        8: ls_mode = 3'd6;
        9: begin ls_mode = 3'd5; usr_code = 10'h2A5; end
        default: ;
      endcase
    end else begin
      ls_mode = ($urandom % 2 == 0) ? 3'd0 : 3'($urandom % 8);
      rq_ctl = 1'($urandom);
      rq_hi = 4'($urandom);
      rq_lo = 4'($urandom);
      usr_code = 10'($urandom);
      bad = ($urandom % 8 == 0);
      if ($urandom % 4 == 0) nrzi_en = ~nrzi_en;
    end
    rq_par = (~^{rq_ctl, rq_hi, rq_lo}) ^ bad;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic line_m = 1'b0;
    logic nrzi_cur = 1'b0;
    int since = 0, k = 0;
    bit first = 1'b1;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    check("R1 line in reset", 16'(line_out), 16'd0);
    check("R1 take in reset", 16'(byte_take), 16'd0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin q_bit.push_back(1'b0); q_tag.push_back("R1 post-reset"); end
    for (int c = 0; c < 12000; c++) begin
      bit b;
      string t;
      @(negedge clk);
      b = q_bit.pop_front();
      t = q_tag.pop_front();
      line_m = nrzi_cur ? (line_m ^ b) : b;
      check(nrzi_cur ? {t, " R11 nrzi"} : {t, " R11 nrz"}, 16'(line_out), 16'(line_m));
      since++;
      if (byte_take) begin
        logic [9:0] w;
        string wt;
        check(first ? "R2 first take" : "R2 take spacing", 16'(since), first ? 16'd9 : 16'd10);
        first = 1'b0;
        since = 0;
        pick(k);
        k++;
        nrzi_cur = nrzi_en;
        w = exp_word(wt);
        for (int i = 9; i >= 0; i--) begin q_bit.push_back(w[i]); q_tag.push_back(wt); end
      end else if (since > 10) begin
        check("R2 take missing", 16'(since), 16'd10);
        since = 0;
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule